// File: doc/BRIEF.md
# Bidirectional Cascaded Column Data Capture

This block is the front end of a 300-channel display column driver. On every clock inside its capture window it takes a 36-bit word holding six 6-bit gray codes and stores it into one group of six channels. A single token walks through a 50-entry chain to pick the group, so one row fills in 50 clocks. A direction input sets whether groups fill from the low channel end upward or from the high end downward. It also sets which of the two start pins receives the start pulse and which one passes a pulse on to the next chip, so several of these blocks can be chained along one row.

A rising edge on the line strobe empties the token chain and ends the capture window. The stored codes are left as they are for the line latch downstream, which reads all 300 codes in parallel. An inversion input can complement every code before it is stored. The data bus has no back-pressure: while the token sits on a group, the word present at that clock edge is taken without any handshake. Outside the window the bus is ignored.

Top module: `colcap_front`

## Requirements
- R1: During reset and right after it, `row_data` is all zeros and both start-pin outputs are low. The output-enables follow `dir_fwd`: `start_l_oe` is high when `dir_fwd` is 1, and `start_r_oe` is high when `dir_fwd` is 0.
- R2: With `dir_fwd`=1, the word present at the clock edge after the edge that samples a start pulse goes to group 0 (channels 0..5). The word on each later edge goes to the next higher group, up to group 49. Code j of the word is `pix_data[6j+5:6j]` (bit 0 is the LSB). It is stored as channel 6g+j at `row_data[(6g+j)*6 +: 6]`.
- R3: With `dir_fwd`=0, the first word after the start pulse goes to group 49, and later words go to successively lower groups down to group 0. The code order inside a group is the same as in R2.
- R4: The start pulse is taken from `start_r_i` when `dir_fwd`=1 and from `start_l_i` when `dir_fwd`=0. A pulse on the other pin has no effect. The cascade pulse is driven on `start_l_o` when `dir_fwd`=1 and on `start_r_o` when `dir_fwd`=0. The pin not in use outputs 0.
- R5: The cascade output is high for exactly one clock period. It rises at the 50th clock edge after the edge that sampled the start pulse, which is the edge that stores the last group.
- R6: Once all 50 groups are written, further words change nothing. The capture window closes by itself 52 clocks after the start pulse and stays closed until the next start pulse.
- R7: A rising edge of `line_strobe`, sampled on a clock edge, empties the token chain and closes the window. Neither the word at that edge nor any later word is stored, and no cascade pulse follows. Data already stored is kept. A strobe held high does not act again.
- R8: When `invert` is 1 at a write edge, each of the six codes is stored bitwise complemented. When it is 0, the codes are stored unchanged.
- R9: A start pulse that arrives while a row is filling restarts the fill from the first group. No word is stored at that edge. If a strobe rising edge and a start pulse arrive at the same edge, the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: fill upward, right pin in / left pin out; 0: the reverse |
| start_r_i | input | 1 | Right start pin, input side |
| start_r_o | output | 1 | Right start pin, output side |
| start_r_oe | output | 1 | Right start pin output-enable |
| start_l_i | input | 1 | Left start pin, input side |
| start_l_o | output | 1 | Left start pin, output side |
| start_l_oe | output | 1 | Left start pin output-enable |
| line_strobe | input | 1 | Line strobe; its rising edge clears the token chain |
| invert | input | 1 | Complement codes before storing |
| pix_data | input | 36 | Six 6-bit gray codes, code j at bits 6j+5..6j |
| row_data | output | 1800 | All 300 stored codes, channel c at bits 6c+5..6c |

## Verification
The hardest states to reach are the collisions: a strobe edge, or a second start pulse, landing in the middle of a fill, or a start pulse arriving on the pin that currently acts as output. Directed sequences place a strobe after ten groups, a restart after seven groups, and a wrong-pin pulse after a direction change. A long random phase then scatters start pulses, strobes, inversion and direction changes at low rates, so these events overlap the window and the wrap-up clocks 51 and 52 in many alignments. An edge-level reference model in the bench tracks each case.

// File: rtl/colcap_pkg.sv
package colcap_pkg;
  localparam int unsigned CODE_W_D    = 6;
  localparam int unsigned CODES_D     = 6;
  localparam int unsigned NUM_GRP_D   = 50;
  localparam int unsigned STOP_CLKS_D = 52;
endpackage

// File: rtl/colcap_token_chain.sv
module colcap_token_chain #(
  parameter int unsigned NUM_GRP = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clear,
  input  logic               advance,
  output logic [NUM_GRP-1:0] token
);
  logic [NUM_GRP-1:0] token_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token_q <= '0;
    end else if (clear) begin
      token_q <= '0;
    end else if (load) begin
      token_q <= {{(NUM_GRP-1){1'b0}}, 1'b1};
    end else if (advance) begin
      token_q <= {token_q[NUM_GRP-2:0], 1'b0};
    end
  end

  assign token = token_q;

  a_r9_token_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_q));
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (token_q == '0));
  a_r9_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> token_q[0]);
endmodule

// File: rtl/colcap_window.sv
module colcap_window #(
  parameter int unsigned STOP_CLKS = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(STOP_CLKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STOP_CLKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= (cnt_q == LIMIT) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign active = (cnt_q != '0);

  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIMIT && !start) |=> !active);
endmodule

// File: rtl/colcap_data_bank.sv
module colcap_data_bank #(
  parameter int unsigned NUM_GRP = 50,
  parameter int unsigned CODES   = 6,
  parameter int unsigned CODE_W  = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [NUM_GRP-1:0]                grp_sel,
  input  logic                              invert,
  input  logic [CODES*CODE_W-1:0]           word,
  output logic [NUM_GRP*CODES*CODE_W-1:0]   row
);
  localparam int unsigned WORD_W = CODES * CODE_W;

  logic [WORD_W-1:0] word_x;

  for (genvar j = 0; j < CODES; j++) begin : g_code
    assign word_x[j*CODE_W +: CODE_W] =
      word[j*CODE_W +: CODE_W] ^ {CODE_W{invert}};
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [WORD_W-1:0] grp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grp_q <= '0;
      end else if (wr_en && grp_sel[g]) begin
        grp_q <= word_x;
      end
    end
    assign row[g*WORD_W +: WORD_W] = grp_q;
  end

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(row));
  a_r2_single_group: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(grp_sel));
endmodule

// File: rtl/colcap_front.sv
module colcap_front
  import colcap_pkg::*;
#(
  parameter int unsigned NUM_GRP   = NUM_GRP_D,
  parameter int unsigned CODES     = CODES_D,
  parameter int unsigned CODE_W    = CODE_W_D,
  parameter int unsigned STOP_CLKS = STOP_CLKS_D,
  parameter int unsigned WORD_W    = CODES * CODE_W,
  parameter int unsigned ROW_W     = NUM_GRP * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              start_r_i,
  output logic              start_r_o,
  output logic              start_r_oe,
  input  logic              start_l_i,
  output logic              start_l_o,
  output logic              start_l_oe,
  input  logic              line_strobe,
  input  logic              invert,
  input  logic [WORD_W-1:0] pix_data,
  output logic [ROW_W-1:0]  row_data
);
  logic               strobe_q;
  logic               strobe_rise;
  logic               start_in;
  logic               load;
  logic               active;
  logic               dir_q;
  logic               wr_en;
  logic               casc_q;
  logic [NUM_GRP-1:0] token;
  logic [NUM_GRP-1:0] token_rev;
  logic [NUM_GRP-1:0] grp_sel;

  assign strobe_rise = line_strobe && !strobe_q;
  assign start_in    = dir_fwd ? start_r_i : start_l_i;
  assign load        = start_in && !strobe_rise;
  assign wr_en       = active && (token != '0) && !start_in && !strobe_rise;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_rev
    assign token_rev[g] = token[NUM_GRP-1-g];
  end
  assign grp_sel = dir_q ? token : token_rev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      dir_q    <= 1'b1;
      casc_q   <= 1'b0;
    end else begin
      strobe_q <= line_strobe;
      if (load) dir_q <= dir_fwd;
      casc_q   <= wr_en && token[NUM_GRP-1];
    end
  end

  colcap_token_chain #(.NUM_GRP(NUM_GRP)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .clear   (strobe_rise),
    .advance (wr_en),
    .token   (token)
  );

  colcap_window #(.STOP_CLKS(STOP_CLKS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (load),
    .clear  (strobe_rise),
    .active (active)
  );

  colcap_data_bank #(.NUM_GRP(NUM_GRP), .CODES(CODES), .CODE_W(CODE_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .grp_sel (grp_sel),
    .invert  (invert),
    .word    (pix_data),
    .row     (row_data)
  );

  assign start_l_oe = dir_fwd;
  assign start_r_oe = !dir_fwd;
  assign start_l_o  = dir_fwd  ? casc_q : 1'b0;
  assign start_r_o  = !dir_fwd ? casc_q : 1'b0;

  a_r5_cascade_single: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q);
  a_r5_cascade_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (active && token[NUM_GRP-1] && !start_in && !strobe_rise) |=> casc_q);
  a_r7_strobe_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !casc_q);
  a_r4_idle_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_l_o && start_r_o));
endmodule

// File: tb/colcap_front_tb_top.sv
module colcap_front_tb_top;
  localparam int NG = 50;
  localparam int NCH = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic dir_fwd, start_r_i, start_l_i, line_strobe, invert;
  logic start_r_o, start_r_oe, start_l_o, start_l_oe;
  logic [35:0] pix_data;
  logic [1799:0] row_data;

  colcap_front dut_i (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
    .start_r_i(start_r_i), .start_r_o(start_r_o), .start_r_oe(start_r_oe),
    .start_l_i(start_l_i), .start_l_o(start_l_o), .start_l_oe(start_l_oe),
    .line_strobe(line_strobe), .invert(invert),
    .pix_data(pix_data), .row_data(row_data)
  );

  always #10 clk = ~clk;

  logic [5:0] exp_code [0:NCH-1];
  int  m_pos, m_cnt;
  bit  m_sprev, m_dirq, m_casc;
  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic check_row(input string tag);
    int bad;
    bad = -1;
    for (int c = 0; c < NCH; c++)
      if (bad < 0 && row_data[c*6 +: 6] !== exp_code[c]) bad = c;
    n_run++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s channel %0d actual=%h expected=%h", tag, bad,
               row_data[bad*6 +: 6], exp_code[bad]);
    end
  endtask

  task automatic check_pins();
    logic [3:0] act, expv;
    act  = {start_l_o, start_r_o, start_l_oe, start_r_oe};
    expv = {dir_fwd ? m_casc : 1'b0, !dir_fwd ? m_casc : 1'b0, dir_fwd, !dir_fwd};
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL R5/R4 pins {l_o,r_o,l_oe,r_oe} actual=%b expected=%b", act, expv);
    end
  endtask

  function automatic logic [35:0] rword();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  task automatic step(input bit sr, input bit sl, input bit stb, input bit inv,
                      input logic [35:0] w, input string tag);
    bit rise, st;
    int grp;
    start_r_i = sr; start_l_i = sl; line_strobe = stb; invert = inv; pix_data = w;
    @(posedge clk);
    rise = stb && !m_sprev;
    m_sprev = stb;
    st = dir_fwd ? sr : sl;
    m_casc = 1'b0;
    if (rise) begin
      m_pos = -1; m_cnt = 0;
    end else if (st) begin
      m_pos = 0; m_cnt = 1; m_dirq = dir_fwd;
    end else if (m_cnt > 0) begin
      if (m_pos >= 0) begin
        grp = m_dirq ? m_pos : NG - 1 - m_pos;
        for (int j = 0; j < 6; j++)
          exp_code[grp*6 + j] = w[j*6 +: 6] ^ {6{inv}};
        if (m_pos == NG - 1) begin m_casc = 1'b1; m_pos = -1; end
        else m_pos = m_pos + 1;
      end
      m_cnt = (m_cnt == 52) ? 0 : m_cnt + 1;
    end
    @(negedge clk);
    check_pins();
    check_row(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) exp_code[c] = '0;
    m_pos = -1; m_cnt = 0; m_sprev = 0; m_dirq = 1; m_casc = 0;
    rst_n = 1'b0; dir_fwd = 1'b1; start_r_i = 0; start_l_i = 0;
    line_strobe = 0; invert = 0; pix_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_row("R1");
    check_pins();
    rst_n = 1'b1;
    @(negedge clk);
    check_row("R1");

    // R2, R5, R6: forward fill, then words past the end
    step(1, 0, 0, 0, rword(), "R2");
    for (int k = 1; k <= 56; k++) step(0, 0, 0, 0, rword(), (k > 50) ? "R6" : "R2");

    // R4: wrong pin ignored after a direction change
    dir_fwd = 1'b0;
    step(1, 0, 0, 0, rword(), "R4");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, rword(), "R4");
    // R3, R8: reverse fill with inversion
    step(0, 1, 0, 1, rword(), "R3");
    for (int k = 1; k <= 54; k++) step(0, 0, 0, 1, rword(), (k % 2) ? "R3" : "R8");
    step(0, 0, 0, 0, 36'hF_C0FF_03F0, "R6");

    // R7: strobe in the middle of a fill
    dir_fwd = 1'b1;
    step(1, 0, 0, 0, rword(), "R7");
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, rword(), "R7");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, rword(), "R7");
    for (int k = 0; k < 45; k++) step(0, 0, 0, 0, rword(), "R7");

    // R9: restart during a fill, and strobe beating start
    step(1, 0, 0, 1, rword(), "R9");
    for (int k = 0; k < 7; k++) step(0, 0, 0, 1, rword(), "R9");
    step(1, 0, 0, 0, rword(), "R9");
    for (int k = 0; k < 55; k++) step(0, 0, 0, 0, rword(), "R9");
    step(1, 0, 1, 0, rword(), "R9");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, rword(), "R9");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 200 == 0) dir_fwd = ~dir_fwd;
      step(($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 60) == 0,
           $urandom % 2 == 1, rword(), dir_fwd ? "R2" : "R3");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule